// File: doc/BRIEF.md
# Stream-to-AXI4 Line Memory Bridge

This block lets a pipelined producer reach memory through five valid/ready streams instead of driving an AXI4 master itself. A read request stream carries a line index and a read line stream returns 64-byte lines. A write request stream carries a line index, a write line stream carries the 64-byte payload, and a write completion stream returns one success flag per finished write. The bridge shifts each index up into a byte address, drives every fixed AXI4 field, and sets the strobe and last flags. Every access is one aligned, full-width beat on a single ID.

The bridge holds no queue and no transaction counter. Each stream is wired through to its AXI4 channel, so a request moves in the same cycle the AXI4 side accepts it. Reads and writes can issue on consecutive cycles, and any number of them can be in flight. The only state is a one-bit gate. It keeps every valid and ready output low during reset and until the first clock edge after reset is released.

Back-pressure rules: each upstream ready equals the matching AXI4 ready while the bridge is live. Each AXI4 ready driven by the bridge (read data, write response) equals the matching downstream ready. A producer must hold its index or line stable while its valid is high and ready is low. The write address and write data streams need no particular order between them.

Top module: `stream_axi_bridge`

## Requirements
- R1: The AXI4 read and write byte addresses equal the line index with six zero bits appended below it. Bits [5:0] are always zero.
- R2: Both address channels drive fixed values: length 0, size 3'b110, burst 2'b01 (incrementing), ID 0, lock 0, cache 4'b0011, protection 3'b000 and QoS 0.
- R3: Every write data beat carries the line unchanged, a 64-bit strobe of all ones, and last set to 1.
- R4: A returned read beat appears on the read line stream unchanged. The read data ready equals the read line stream ready.
- R5: The completion flag is 1 when the write response code is 2'b00 and 0 for 2'b01, 2'b10 and 2'b11. The write response ready equals the completion stream ready.
- R6: The write address and write data streams are accepted independently. Either may complete its handshake before the other, or both may complete in the same cycle.
- R7: Read requests keep being accepted while no read data has come back. The bridge sets no limit on outstanding reads.
- R8: A request is accepted in the same cycle that its AXI4 handshake completes. A new request can be accepted on every consecutive cycle, with no idle cycle between them.
- R9: When an AXI4 address or write data ready is low, the matching upstream ready is low and nothing is accepted.
- R10: While reset is asserted, and until the first rising clock edge with reset released, every valid and ready output of the bridge is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready |
| rd_req_idx | input | 34 | Read line index |
| rd_line_valid | output | 1 | Read line valid |
| rd_line_ready | input | 1 | Read line ready |
| rd_line_data | output | 512 | Read line payload |
| wr_req_valid | input | 1 | Write address request valid |
| wr_req_ready | output | 1 | Write address request ready |
| wr_req_idx | input | 34 | Write line index |
| wr_line_valid | input | 1 | Write line valid |
| wr_line_ready | output | 1 | Write line ready |
| wr_line_data | input | 512 | Write line payload |
| wr_done_valid | output | 1 | Write completion valid |
| wr_done_ready | input | 1 | Write completion ready |
| wr_done_ok | output | 1 | 1 when the write succeeded |
| m_arvalid | output | 1 | AXI4 read address valid |
| m_arready | input | 1 | AXI4 read address ready |
| m_araddr | output | 40 | AXI4 read byte address |
| m_arid | output | 2 | AXI4 read ID |
| m_arlen | output | 8 | AXI4 read burst length |
| m_arsize | output | 3 | AXI4 read beat size |
| m_arburst | output | 2 | AXI4 read burst type |
| m_arlock | output | 1 | AXI4 read lock |
| m_arcache | output | 4 | AXI4 read cache attributes |
| m_arprot | output | 3 | AXI4 read protection |
| m_arqos | output | 4 | AXI4 read QoS |
| m_rvalid | input | 1 | AXI4 read data valid |
| m_rready | output | 1 | AXI4 read data ready |
| m_rdata | input | 512 | AXI4 read data |
| m_awvalid | output | 1 | AXI4 write address valid |
| m_awready | input | 1 | AXI4 write address ready |
| m_awaddr | output | 40 | AXI4 write byte address |
| m_awid | output | 2 | AXI4 write ID |
| m_awlen | output | 8 | AXI4 write burst length |
| m_awsize | output | 3 | AXI4 write beat size |
| m_awburst | output | 2 | AXI4 write burst type |
| m_awlock | output | 1 | AXI4 write lock |
| m_awcache | output | 4 | AXI4 write cache attributes |
| m_awprot | output | 3 | AXI4 write protection |
| m_awqos | output | 4 | AXI4 write QoS |
| m_wvalid | output | 1 | AXI4 write data valid |
| m_wready | input | 1 | AXI4 write data ready |
| m_wdata | output | 512 | AXI4 write data |
| m_wstrb | output | 64 | AXI4 write strobes |
| m_wlast | output | 1 | AXI4 write last beat |
| m_bvalid | input | 1 | AXI4 write response valid |
| m_bready | output | 1 | AXI4 write response ready |
| m_bresp | input | 2 | AXI4 write response code |

## Verification
The hardest case to reach is a long run of reads accepted on consecutive cycles with no read data returned. This is the condition that would show a hidden cap on outstanding reads or an idle cycle between requests. The stimulus holds the AXI4 read address ready high and never raises read data valid. It then presents a fresh index in each of twenty cycles and counts one completed handshake per cycle. Write address and write data arrive in both orders and together. Every write response code is applied in turn.

// File: rtl/stream_axi_pkg.sv
package stream_axi_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  function automatic logic [2:0] size_code(input int unsigned bytes);
    return 3'($clog2(bytes));
  endfunction
endpackage

// File: rtl/sab_addr_chan.sv
module sab_addr_chan
  import stream_axi_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ID_W       = 2,
  parameter logic [3:0]  CACHE_VAL  = 4'b0011,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W     = ADDR_W - OFF_W
) (
  input  logic              live,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              ax_valid,
  input  logic              ax_ready,
  output logic [ADDR_W-1:0] ax_addr,
  output logic [ID_W-1:0]   ax_id,
  output logic [7:0]        ax_len,
  output logic [2:0]        ax_size,
  output logic [1:0]        ax_burst,
  output logic              ax_lock,
  output logic [3:0]        ax_cache,
  output logic [2:0]        ax_prot,
  output logic [3:0]        ax_qos
);
  always_comb begin
    ax_valid = live & in_valid;
    in_ready = live & ax_ready;
    ax_addr  = {in_idx, {OFF_W{1'b0}}};
    ax_id    = '0;
    ax_len   = 8'd0;
    ax_size  = size_code(LINE_BYTES);
    ax_burst = BURST_INCR;
    ax_lock  = 1'b0;
    ax_cache = CACHE_VAL;
    ax_prot  = 3'b000;
    ax_qos   = 4'd0;
  end
endmodule

// File: rtl/sab_wline_chan.sv
module sab_wline_chan #(
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned DATA_W    = LINE_BYTES * 8
) (
  input  logic                  live,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  w_valid,
  input  logic                  w_ready,
  output logic [DATA_W-1:0]     w_data,
  output logic [LINE_BYTES-1:0] w_strb,
  output logic                  w_last
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_strb
    assign w_strb[b] = 1'b1;
  end

  always_comb begin
    w_valid  = live & in_valid;
    in_ready = live & w_ready;
    w_data   = in_data;
    w_last   = 1'b1;
  end
endmodule

// File: rtl/sab_resp_chan.sv
module sab_resp_chan
  import stream_axi_pkg::*;
#(
  parameter int unsigned DATA_W = 512
) (
  input  logic              live,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [DATA_W-1:0] line_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [1:0]        b_resp,
  output logic              done_valid,
  input  logic              done_ready,
  output logic              done_ok
);
  always_comb begin
    line_valid = live & r_valid;
    r_ready    = live & line_ready;
    line_data  = r_data;
    done_valid = live & b_valid;
    b_ready    = live & done_ready;
    done_ok    = (b_resp == RESP_OKAY);
  end
endmodule

// File: rtl/stream_axi_bridge.sv
module stream_axi_bridge #(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ID_W       = 2,
  parameter logic [3:0]  CACHE_VAL  = 4'b0011,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W     = ADDR_W - OFF_W,
  localparam int unsigned DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req_valid,
  output logic                  rd_req_ready,
  input  logic [IDX_W-1:0]      rd_req_idx,
  output logic                  rd_line_valid,
  input  logic                  rd_line_ready,
  output logic [DATA_W-1:0]     rd_line_data,
  input  logic                  wr_req_valid,
  output logic                  wr_req_ready,
  input  logic [IDX_W-1:0]      wr_req_idx,
  input  logic                  wr_line_valid,
  output logic                  wr_line_ready,
  input  logic [DATA_W-1:0]     wr_line_data,
  output logic                  wr_done_valid,
  input  logic                  wr_done_ready,
  output logic                  wr_done_ok,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  output logic [ADDR_W-1:0]     m_araddr,
  output logic [ID_W-1:0]       m_arid,
  output logic [7:0]            m_arlen,
  output logic [2:0]            m_arsize,
  output logic [1:0]            m_arburst,
  output logic                  m_arlock,
  output logic [3:0]            m_arcache,
  output logic [2:0]            m_arprot,
  output logic [3:0]            m_arqos,
  input  logic                  m_rvalid,
  output logic                  m_rready,
  input  logic [DATA_W-1:0]     m_rdata,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [ID_W-1:0]       m_awid,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_awlock,
  output logic [3:0]            m_awcache,
  output logic [2:0]            m_awprot,
  output logic [3:0]            m_awqos,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [LINE_BYTES-1:0] m_wstrb,
  output logic                  m_wlast,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  input  logic [1:0]            m_bresp
);
  logic live;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  sab_addr_chan #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ID_W(ID_W), .CACHE_VAL(CACHE_VAL)
  ) u_ar (
    .live(live), .in_valid(rd_req_valid), .in_ready(rd_req_ready), .in_idx(rd_req_idx),
    .ax_valid(m_arvalid), .ax_ready(m_arready), .ax_addr(m_araddr), .ax_id(m_arid),
    .ax_len(m_arlen), .ax_size(m_arsize), .ax_burst(m_arburst), .ax_lock(m_arlock),
    .ax_cache(m_arcache), .ax_prot(m_arprot), .ax_qos(m_arqos)
  );

  sab_addr_chan #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ID_W(ID_W), .CACHE_VAL(CACHE_VAL)
  ) u_aw (
    .live(live), .in_valid(wr_req_valid), .in_ready(wr_req_ready), .in_idx(wr_req_idx),
    .ax_valid(m_awvalid), .ax_ready(m_awready), .ax_addr(m_awaddr), .ax_id(m_awid),
    .ax_len(m_awlen), .ax_size(m_awsize), .ax_burst(m_awburst), .ax_lock(m_awlock),
    .ax_cache(m_awcache), .ax_prot(m_awprot), .ax_qos(m_awqos)
  );

  sab_wline_chan #(.LINE_BYTES(LINE_BYTES)) u_w (
    .live(live), .in_valid(wr_line_valid), .in_ready(wr_line_ready), .in_data(wr_line_data),
    .w_valid(m_wvalid), .w_ready(m_wready), .w_data(m_wdata), .w_strb(m_wstrb),
    .w_last(m_wlast)
  );

  sab_resp_chan #(.DATA_W(DATA_W)) u_rsp (
    .live(live), .r_valid(m_rvalid), .r_ready(m_rready), .r_data(m_rdata),
    .line_valid(rd_line_valid), .line_ready(rd_line_ready), .line_data(rd_line_data),
    .b_valid(m_bvalid), .b_ready(m_bready), .b_resp(m_bresp),
    .done_valid(wr_done_valid), .done_ready(wr_done_ready), .done_ok(wr_done_ok)
  );
endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_req_valid,
  input logic                  rd_req_ready,
  input logic                  wr_req_valid,
  input logic                  wr_req_ready,
  input logic                  wr_line_valid,
  input logic                  wr_line_ready,
  input logic                  m_arvalid,
  input logic                  m_arready,
  input logic [ADDR_W-1:0]     m_araddr,
  input logic                  m_awvalid,
  input logic                  m_awready,
  input logic [ADDR_W-1:0]     m_awaddr,
  input logic                  m_wvalid,
  input logic                  m_wready,
  input logic [LINE_BYTES-1:0] m_wstrb,
  input logic                  m_wlast,
  input logic                  m_rready,
  input logic                  m_bvalid,
  input logic                  m_bready,
  input logic [1:0]            m_bresp,
  input logic                  wr_done_valid,
  input logic                  wr_done_ok
);
  a_r1_ar_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (m_araddr[OFF_W-1:0] == '0));
  a_r1_aw_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (m_awaddr[OFF_W-1:0] == '0));
  a_r3_full_beat: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> (&m_wstrb && m_wlast));
  a_r5_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done_valid && m_bvalid) |-> (wr_done_ok == (m_bresp == 2'b00)));
  a_r8_rd_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) == (m_arvalid && m_arready));
  a_r6_wa_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && wr_req_ready) == (m_awvalid && m_awready));
  a_r6_wd_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_line_valid && wr_line_ready) == (m_wvalid && m_wready));
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(m_arvalid || m_awvalid || m_wvalid || m_rready || m_bready));
endmodule

bind stream_axi_bridge sab_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
  .wr_line_valid(wr_line_valid), .wr_line_ready(wr_line_ready),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
  .m_rready(m_rready), .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
  .wr_done_valid(wr_done_valid), .wr_done_ok(wr_done_ok)
);

// File: tb/sim_stream_axi_bridge.sv
module sim_stream_axi_bridge;
  localparam int unsigned ADDR_W = 40;
  localparam int unsigned LB     = 64;
  localparam int unsigned IDX_W  = ADDR_W - 6;
  localparam int unsigned DW     = LB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic rd_req_valid = 0, rd_line_ready = 0, wr_req_valid = 0, wr_line_valid = 0, wr_done_ready = 0;
  logic [IDX_W-1:0] rd_req_idx = '0, wr_req_idx = '0;
  logic [DW-1:0] wr_line_data = '0, m_rdata = '0;
  logic m_arready = 0, m_rvalid = 0, m_awready = 0, m_wready = 0, m_bvalid = 0;
  logic [1:0] m_bresp = 2'b00;

  logic rd_req_ready, rd_line_valid, wr_req_ready, wr_line_ready, wr_done_valid, wr_done_ok;
  logic [DW-1:0] rd_line_data, m_wdata;
  logic m_arvalid, m_rready, m_awvalid, m_wvalid, m_wlast, m_bready, m_arlock, m_awlock;
  logic [ADDR_W-1:0] m_araddr, m_awaddr;
  logic [1:0] m_arid, m_awid, m_arburst, m_awburst;
  logic [7:0] m_arlen, m_awlen;
  logic [2:0] m_arsize, m_awsize, m_arprot, m_awprot;
  logic [3:0] m_arcache, m_awcache, m_arqos, m_awqos;
  logic [LB-1:0] m_wstrb;

  stream_axi_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_idx(rd_req_idx),
    .rd_line_valid(rd_line_valid), .rd_line_ready(rd_line_ready), .rd_line_data(rd_line_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_idx(wr_req_idx),
    .wr_line_valid(wr_line_valid), .wr_line_ready(wr_line_ready), .wr_line_data(wr_line_data),
    .wr_done_valid(wr_done_valid), .wr_done_ready(wr_done_ready), .wr_done_ok(wr_done_ok),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arid(m_arid),
    .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst), .m_arlock(m_arlock),
    .m_arcache(m_arcache), .m_arprot(m_arprot), .m_arqos(m_arqos),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awid(m_awid),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awlock(m_awlock),
    .m_awcache(m_awcache), .m_awprot(m_awprot), .m_awqos(m_awqos),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mkline(input int seed);
    logic [DW-1:0] l;
    for (int k = 0; k < DW / 32; k++) l[k*32 +: 32] = 32'(seed * 7919 + k * 31);
    return l;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_all();
    rd_req_valid = 0; wr_req_valid = 0; wr_line_valid = 0; m_rvalid = 0; m_bvalid = 0;
    m_arready = 0; m_awready = 0; m_wready = 0; rd_line_ready = 0; wr_done_ready = 0;
  endtask

  task automatic t_reset();
    rd_req_valid = 1; wr_req_valid = 1; wr_line_valid = 1; m_rvalid = 1; m_bvalid = 1;
    m_arready = 1; m_awready = 1; m_wready = 1; rd_line_ready = 1; wr_done_ready = 1;
    repeat (3) step();
    settle();
    chk({m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready} == 5'b0, "R10 in reset axi",
        64'({m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready}), 64'd0);
    chk({rd_req_ready, wr_req_ready, wr_line_ready, rd_line_valid, wr_done_valid} == 5'b0,
        "R10 in reset streams",
        64'({rd_req_ready, wr_req_ready, wr_line_ready, rd_line_valid, wr_done_valid}), 64'd0);
    rst_n = 1;
    settle();
    chk(m_arvalid == 0 && m_rready == 0, "R10 before first edge",
        64'({m_arvalid, m_rready}), 64'd0);
    step();
    settle();
    chk(m_arvalid && m_awvalid && m_wvalid && m_rready && m_bready, "R10 live after edge",
        64'({m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready}), 64'h1f);
    idle_all();
  endtask

  task automatic t_fields();
    step();
    rd_req_valid = 1; rd_req_idx = 34'h2_abcd_1234;
    wr_req_valid = 1; wr_req_idx = 34'h3_ffff_ffff;
    settle();
    chk(m_araddr == {rd_req_idx, 6'b0}, "R1 read address", 64'(m_araddr), 64'({rd_req_idx, 6'b0}));
    chk(m_awaddr == {wr_req_idx, 6'b0}, "R1 write address", 64'(m_awaddr), 64'({wr_req_idx, 6'b0}));
    chk({m_arid, m_arlen, m_arsize, m_arburst, m_arlock, m_arcache, m_arprot, m_arqos} ==
        {2'd0, 8'd0, 3'b110, 2'b01, 1'b0, 4'b0011, 3'b000, 4'd0}, "R2 read fields",
        64'({m_arid, m_arlen, m_arsize, m_arburst, m_arlock, m_arcache, m_arprot, m_arqos}),
        64'({2'd0, 8'd0, 3'b110, 2'b01, 1'b0, 4'b0011, 3'b000, 4'd0}));
    chk({m_awid, m_awlen, m_awsize, m_awburst, m_awlock, m_awcache, m_awprot, m_awqos} ==
        {2'd0, 8'd0, 3'b110, 2'b01, 1'b0, 4'b0011, 3'b000, 4'd0}, "R2 write fields",
        64'({m_awid, m_awlen, m_awsize, m_awburst, m_awlock, m_awcache, m_awprot, m_awqos}),
        64'({2'd0, 8'd0, 3'b110, 2'b01, 1'b0, 4'b0011, 3'b000, 4'd0}));
    idle_all();
  endtask

  task automatic t_read_burst_of_singles();
    int accepted = 0;
    int gap = 0;
    for (int n = 0; n < 20; n++) begin
      step();
      rd_req_valid = 1; m_arready = 1; rd_req_idx = IDX_W'(n * 3 + 5);
      settle();
      if (m_arvalid && m_arready && rd_req_ready && m_araddr == {rd_req_idx, 6'b0}) accepted++;
      else gap++;
    end
    chk(accepted == 20, "R7 reads accepted with no data back", 64'(accepted), 64'd20);
    chk(gap == 0, "R8 no idle cycle between reads", 64'(gap), 64'd0);
    idle_all();
  endtask

  task automatic t_backpressure();
    step();
    rd_req_valid = 1; rd_req_idx = 34'h11; m_arready = 0;
    wr_req_valid = 1; m_awready = 0; wr_line_valid = 1; m_wready = 0;
    settle();
    chk(!rd_req_ready && m_arvalid, "R9 read stalled", 64'({rd_req_ready, m_arvalid}), 64'h1);
    chk(!wr_req_ready && !wr_line_ready, "R9 write stalled",
        64'({wr_req_ready, wr_line_ready}), 64'h0);
    step();
    m_arready = 1;
    settle();
    chk(rd_req_ready, "R8 accept in ready cycle", 64'(rd_req_ready), 64'd1);
    idle_all();
  endtask

  task automatic t_write_order();
    step();
    wr_line_valid = 1; wr_line_data = mkline(9); m_wready = 1;
    settle();
    chk(m_wvalid && wr_line_ready && !m_awvalid, "R6 data before address",
        64'({m_wvalid, wr_line_ready, m_awvalid}), 64'h6);
    chk(m_wdata == wr_line_data, "R3 write data", m_wdata[63:0], wr_line_data[63:0]);
    chk(m_wstrb == {LB{1'b1}} && m_wlast, "R3 strobe and last", m_wstrb, 64'hffff_ffff_ffff_ffff);
    step();
    wr_line_valid = 0; m_wready = 0;
    wr_req_valid = 1; wr_req_idx = 34'h77; m_awready = 1;
    settle();
    chk(m_awvalid && wr_req_ready && !m_wvalid, "R6 address before data",
        64'({m_awvalid, wr_req_ready, m_wvalid}), 64'h6);
    step();
    wr_line_valid = 1; m_wready = 1; m_awready = 0;
    settle();
    chk(wr_line_ready && !wr_req_ready, "R6 data moves while address waits",
        64'({wr_line_ready, wr_req_ready}), 64'h2);
    idle_all();
  endtask

  task automatic t_write_done();
    for (int c = 0; c < 4; c++) begin
      step();
      m_bvalid = 1; m_bresp = 2'(c); wr_done_ready = 1;
      settle();
      chk(wr_done_valid && m_bready && (wr_done_ok == (c == 0)), "R5 completion flag",
          64'({wr_done_valid, m_bready, wr_done_ok}), 64'({2'b11, c == 0}));
    end
    step();
    wr_done_ready = 0;
    settle();
    chk(!m_bready, "R5 response held by downstream", 64'(m_bready), 64'd0);
    idle_all();
  endtask

  task automatic t_read_data();
    for (int n = 0; n < 3; n++) begin
      step();
      m_rvalid = 1; m_rdata = mkline(100 + n); rd_line_ready = (n != 1);
      settle();
      chk(rd_line_valid && rd_line_data == m_rdata, "R4 read line passes",
          rd_line_data[63:0], m_rdata[63:0]);
      chk(m_rready == (n != 1), "R4 read ready follows", 64'(m_rready), 64'(n != 1));
    end
    idle_all();
  endtask

  initial begin
    t_reset();
    t_fields();
    t_read_burst_of_singles();
    t_backpressure();
    t_write_order();
    t_write_done();
    t_read_data();
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule